// File: doc/BRIEF.md
# Panel Power-Up Sequencer

This block brings an LCD panel out of power-off by raising five level enables in a fixed order: panel supply, LVDS link, backlight supply, backlight PWM, and backlight enable. A done flag rises together with the final enable. Before the block may run the next stage, each of the first four stage executions arms its own programmable hold-off, counted in milliseconds. The block builds its time base by counting pulses on a one-microsecond tick input. It has no clock of its own for time.

A request strobe moves the sequence forward. When the mode input is low at the request, the block runs at most one stage. If the hold-off for that stage has not yet expired, the request does nothing. When the mode input is high at the request, the block latches a run flag. It then steps through every remaining stage as each hold-off expires and stops at done. After done, only a reset clears the enables. The PWM generator, pin routing and regulators are outside this block. The block reports the PWM high-time setting for the PWM generator to use.

Top module: `pseq_top`

## Requirements
- R1: A synchronous reset, with rst_n low at a clock edge, clears all five enables, seq_done, pwm_duty and the stage position. The stage position returns to the start stage.
- R2: The stages run in this order: start (index 0), panel supply (1), LVDS (2), backlight supply (3), backlight PWM (4), backlight enable (5). Each stage from 1 to 5 sets its own enable in the cycle after the clock edge that executes it. seq_done rises in the same cycle as bl_en.
- R3: The start stage runs on the first request after reset. It does not wait for any deadline and changes no output.
- R4: Executing stage i, for i from 0 to 3, loads a hold-off of gate<i>_ms milliseconds, where one millisecond is TICKS_PER_MS sampled us_tick pulses. The next stage can first execute on the clock edge after the edge at which the hold-off reaches zero. With a zero hold-off, that is the next edge.
- R5: Executing stage 4 or stage 5 arms no hold-off. The stage that follows is eligible on the next edge.
- R6: With wait_mode low, a request executes at most one stage. A request made while the hold-off has not expired changes nothing. Without a request or a latched run, the outputs hold.
- R7: With wait_mode high, a single request steps through all remaining stages as their hold-offs expire, up to done, with no further requests.
- R8: pwm_duty reads 0xDF (parameter DUTY_ON) from the cycle bl_pwm_en rises, and 0 before that.
- R9: Once seq_done is high, requests in either mode change no output.
- R10: Once set, an enable stays high until reset.
- R11: The hold-off counts only clock edges at which us_tick is high. With us_tick low, no deadline comes closer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Request strobe to advance the sequence |
| wait_mode | input | 1 | 1: run to completion; 0: at most one stage per request |
| us_tick | input | 1 | One-microsecond time base pulse |
| gate0_ms | input | MS_W | Hold-off after the start stage |
| gate1_ms | input | MS_W | Hold-off after panel supply on |
| gate2_ms | input | MS_W | Hold-off after LVDS on |
| gate3_ms | input | MS_W | Hold-off after backlight supply on |
| panel_pwr_en | output | 1 | Panel supply enable |
| link_en | output | 1 | LVDS enable |
| bl_pwr_en | output | 1 | Backlight supply enable |
| bl_pwm_en | output | 1 | Backlight PWM enable |
| bl_en | output | 1 | Backlight enable |
| pwm_duty | output | DUTY_W | PWM high time out of full scale |
| seq_done | output | 1 | Sequence complete |

## Verification
The bench runs the sequence to completion in wait mode twice. One run uses mixed non-zero hold-offs and the other uses all-zero hold-offs. Each enable edge is matched to its expected cycle, which separates correct stage ordering and hold-off indexing from off-by-one millisecond counting. A stepped run in non-wait mode sends early requests, repeated requests and requests after done. This tells apart a design that drops early requests from one that queues them, and one that steps once per request from one that runs ahead. A run with a gated tick holds us_tick low, then gives exactly one tick short of a millisecond, then the last tick. This shows that time advances only on ticks and that expiry falls exactly on the boundary.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  typedef enum logic [2:0] {
    ST_START = 3'd0,
    ST_PANEL = 3'd1,
    ST_LINK  = 3'd2,
    ST_BLSUP = 3'd3,
    ST_DIM   = 3'd4,
    ST_BLON  = 3'd5,
    ST_DONE  = 3'd6
  } pseq_stage_e;

  // stages 0..N_GATED-1 arm a hold-off after they execute
  localparam int unsigned N_GATED = 4;
  // number of level enables driven (stages 1..N_RAILS)
  localparam int unsigned N_RAILS = 5;

endpackage

// File: rtl/pseq_ms_timer.sv
module pseq_ms_timer #(
  parameter int unsigned TICKS_PER_MS = 1000,
  parameter int unsigned MS_W         = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [MS_W-1:0] ms_i,
  input  logic            tick_i,
  output logic            expired_o
);

  localparam int unsigned US_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [US_W-1:0] US_LAST = US_W'(TICKS_PER_MS - 1);

  logic [MS_W-1:0] ms_left_q;
  logic [US_W-1:0] us_cnt_q;
  logic            ms_wrap;

  generate
    if (TICKS_PER_MS > 1) begin : g_prescale
      assign ms_wrap = (us_cnt_q == US_LAST);
    end else begin : g_direct
      assign ms_wrap = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ms_left_q <= '0;
      us_cnt_q  <= '0;
    end else if (load_i) begin
      ms_left_q <= ms_i;
      us_cnt_q  <= '0;
    end else if (tick_i && (ms_left_q != '0)) begin
      if (ms_wrap) begin
        us_cnt_q  <= '0;
        ms_left_q <= ms_left_q - 1'b1;
      end else begin
        us_cnt_q  <= us_cnt_q + 1'b1;
      end
    end
  end

  assign expired_o = (ms_left_q == '0);

endmodule

// File: rtl/pseq_stage_ctrl.sv
module pseq_stage_ctrl
  import pseq_pkg::*;
#(
  parameter int unsigned MS_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_i,
  input  logic                    wait_i,
  input  logic                    expired_i,
  input  logic [N_GATED*MS_W-1:0] gates_i,
  output logic                    step_o,
  output pseq_stage_e             stage_o,
  output logic [MS_W-1:0]         load_ms_o,
  output logic                    running_o
);

  pseq_stage_e cur_q;
  logic        run_q;
  logic        ready;

  always_comb begin
    ready     = (cur_q == ST_START) || expired_i;
    step_o    = (req_i || run_q) && (cur_q != ST_DONE) && ready;
    load_ms_o = '0;
    for (int k = 0; k < N_GATED; k++) begin
      if (cur_q == pseq_stage_e'(3'(k))) load_ms_o = gates_i[k*MS_W +: MS_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= ST_START;
      run_q <= 1'b0;
    end else begin
      if (step_o) cur_q <= pseq_stage_e'(cur_q + 3'd1);
      if (cur_q == ST_DONE)       run_q <= 1'b0;
      else if (req_i && wait_i)   run_q <= 1'b1;
    end
  end

  assign stage_o   = cur_q;
  assign running_o = run_q;

endmodule

// File: rtl/pseq_enable_bank.sv
module pseq_enable_bank
  import pseq_pkg::*;
#(
  parameter int unsigned          DUTY_W  = 8,
  parameter logic [DUTY_W-1:0]    DUTY_ON = 'hDF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_i,
  input  pseq_stage_e        stage_i,
  output logic [N_RAILS-1:0] rails_o,
  output logic               done_o,
  output logic [DUTY_W-1:0]  duty_o
);

  genvar g;
  generate
    for (g = 0; g < N_RAILS; g++) begin : g_rail
      always_ff @(posedge clk) begin
        if (!rst_n)
          rails_o[g] <= 1'b0;
        else if (step_i && (stage_i == pseq_stage_e'(3'(g + 1))))
          rails_o[g] <= 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      duty_o <= '0;
    end else if (step_i) begin
      if (stage_i == ST_BLON) done_o <= 1'b1;
      if (stage_i == ST_DIM)  duty_o <= DUTY_ON;
    end
  end

endmodule

// File: rtl/pseq_top.sv
module pseq_top
  import pseq_pkg::*;
#(
  parameter int unsigned       TICKS_PER_MS = 1000,
  parameter int unsigned       MS_W         = 16,
  parameter int unsigned       DUTY_W       = 8,
  parameter logic [DUTY_W-1:0] DUTY_ON      = 'hDF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wait_mode,
  input  logic              us_tick,
  input  logic [MS_W-1:0]   gate0_ms,
  input  logic [MS_W-1:0]   gate1_ms,
  input  logic [MS_W-1:0]   gate2_ms,
  input  logic [MS_W-1:0]   gate3_ms,
  output logic              panel_pwr_en,
  output logic              link_en,
  output logic              bl_pwr_en,
  output logic              bl_pwm_en,
  output logic              bl_en,
  output logic [DUTY_W-1:0] pwm_duty,
  output logic              seq_done
);

  logic [N_GATED*MS_W-1:0] gates;
  logic                    step;
  logic                    running;
  logic                    expired;
  logic [MS_W-1:0]         load_ms;
  pseq_stage_e             stage;
  logic [N_RAILS-1:0]      rails;

  assign gates = {gate3_ms, gate2_ms, gate1_ms, gate0_ms};

  pseq_stage_ctrl #(.MS_W(MS_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req),
    .wait_i    (wait_mode),
    .expired_i (expired),
    .gates_i   (gates),
    .step_o    (step),
    .stage_o   (stage),
    .load_ms_o (load_ms),
    .running_o (running)
  );

  pseq_ms_timer #(.TICKS_PER_MS(TICKS_PER_MS), .MS_W(MS_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (step),
    .ms_i      (load_ms),
    .tick_i    (us_tick),
    .expired_o (expired)
  );

  pseq_enable_bank #(.DUTY_W(DUTY_W), .DUTY_ON(DUTY_ON)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (step),
    .stage_i (stage),
    .rails_o (rails),
    .done_o  (seq_done),
    .duty_o  (pwm_duty)
  );

  assign panel_pwr_en = rails[0];
  assign link_en      = rails[1];
  assign bl_pwr_en    = rails[2];
  assign bl_pwm_en    = rails[3];
  assign bl_en        = rails[4];

endmodule

// File: rtl/pseq_checker.sv
module pseq_checker #(
  parameter int unsigned       DUTY_W  = 8,
  parameter logic [DUTY_W-1:0] DUTY_ON = 'hDF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              run_i,
  input logic [4:0]        rails,
  input logic              done,
  input logic [DUTY_W-1:0] duty
);

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rails[1] |-> rails[0]) and (rails[2] |-> rails[1]) and
    (rails[3] |-> rails[2]) and (rails[4] |-> rails[3]));

  p_done_with_bl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rails[4]);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((rails & $past(rails)) == $past(rails)));

  p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ($countones(rails ^ $past(rails)) <= 1));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !req && !run_i) |=> $stable(rails));

  p_duty_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rails[3] |-> (duty == DUTY_ON));

  p_duty_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rails[3] |-> (duty == '0));

  p_done_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && done) |=> (done && $stable(rails)));

endmodule

bind pseq_top pseq_checker #(.DUTY_W(DUTY_W), .DUTY_ON(DUTY_ON)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .req   (req),
  .run_i (running),
  .rails (rails),
  .done  (seq_done),
  .duty  (pwm_duty)
);

// File: tb/sim_pseq_top.sv
module sim_pseq_top;

  localparam int TPM = 1000;

  typedef struct {
    int         c;
    logic [5:0] v;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        wait_mode = 1'b0;
  logic        us_tick = 1'b0;
  logic [15:0] g0 = '0, g1 = '0, g2 = '0, g3 = '0;
  logic        panel_pwr_en, link_en, bl_pwr_en, bl_pwm_en, bl_en, seq_done;
  logic [7:0]  pwm_duty;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_err = 0;
  exp_t q[$];
  exp_t x;
  logic [5:0] prev;
  logic [5:0] vec;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pseq_top u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .wait_mode(wait_mode), .us_tick(us_tick),
    .gate0_ms(g0), .gate1_ms(g1), .gate2_ms(g2), .gate3_ms(g3),
    .panel_pwr_en(panel_pwr_en), .link_en(link_en), .bl_pwr_en(bl_pwr_en),
    .bl_pwm_en(bl_pwm_en), .bl_en(bl_en), .pwm_duty(pwm_duty), .seq_done(seq_done)
  );

  assign vec = {seq_done, bl_en, bl_pwm_en, bl_pwr_en, link_en, panel_pwr_en};

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic push(input int c, input logic [5:0] v, input string tag);
    exp_t e;
    e.c = c; e.v = v; e.tag = tag;
    q.push_back(e);
  endtask

  // scoreboard monitor: every output change must match the next expected item
  always @(negedge clk) begin
    if (!rst_n) begin
      prev = vec;
    end else if (vec !== prev) begin
      if (q.size() == 0) begin
        chk(1'b0, "R6", "unexpected output change", longint'(vec), longint'(prev));
      end else begin
        x = q.pop_front();
        chk(vec == x.v, "R2", "enable vector", longint'(vec), longint'(x.v));
        chk(cyc == x.c, x.tag, "change cycle", longint'(cyc), longint'(x.c));
      end
      prev = vec;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = 1'b0;
    repeat (3) @(negedge clk);
    q.delete();
    rst_n = 1'b1;
    @(negedge clk);
    chk(vec == 6'b0, "R1", "enables after reset", longint'(vec), 0);
    chk(pwm_duty == 8'h00, "R1", "duty after reset", longint'(pwm_duty), 0);
  endtask

  // one-cycle request; optionally pushes the single change it should cause
  task automatic req_one(input bit expect_chg, input logic [5:0] v, input string tag);
    @(negedge clk);
    if (expect_chg) push(cyc + 1, v, tag);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 20 && q.size() != 0; i++) @(negedge clk);
    chk(q.size() == 0, tag, "expected changes outstanding", q.size(), 0);
  endtask

  task automatic full_run(input int d0, input int d1, input int d2, input int d3);
    int t;
    g0 = 16'(d0); g1 = 16'(d1); g2 = 16'(d2); g3 = 16'(d3);
    wait_mode = 1'b1; us_tick = 1'b1;
    @(negedge clk);
    t = cyc + 1 + TPM * d0 + 1;  push(t, 6'b000001, "R3");
    t = t + TPM * d1 + 1;        push(t, 6'b000011, "R4");
    t = t + TPM * d2 + 1;        push(t, 6'b000111, "R4");
    t = t + TPM * d3 + 1;        push(t, 6'b001111, "R4");
    t = t + 1;                   push(t, 6'b111111, "R5");
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    while (!seq_done) @(negedge clk);
    @(negedge clk);
    drain("R7");
    chk(seq_done == 1'b1, "R7", "done after single wait-mode request", longint'(seq_done), 1);
    chk(pwm_duty == 8'hDF, "R8", "duty when PWM on", longint'(pwm_duty), 8'hDF);
  endtask

  initial begin
    do_reset();

    // wait mode, mixed hold-offs
    full_run(1, 0, 2, 1);
    repeat (50) @(negedge clk);
    chk(vec == 6'b111111, "R10", "enables held after done", longint'(vec), 6'h3F);

    // wait mode, all zero hold-offs
    do_reset();
    full_run(0, 0, 0, 0);

    // non-wait stepping
    do_reset();
    wait_mode = 1'b0; us_tick = 1'b1;
    g0 = 16'd2; g1 = 16'd0; g2 = 16'd1; g3 = 16'd0;
    req_one(1'b0, 6'b0, "R3");
    req_one(1'b0, 6'b0, "R6");
    repeat (5) @(negedge clk);
    chk(vec == 6'b0, "R6", "early request ignored", longint'(vec), 0);
    repeat (2100) @(negedge clk);
    req_one(1'b1, 6'b000001, "R3");
    repeat (10) @(negedge clk);
    chk(vec == 6'b000001, "R6", "one stage per request", longint'(vec), 1);
    chk(pwm_duty == 8'h00, "R8", "duty before PWM stage", longint'(pwm_duty), 0);
    req_one(1'b1, 6'b000011, "R4");
    req_one(1'b0, 6'b0, "R4");
    repeat (3) @(negedge clk);
    chk(vec == 6'b000011, "R4", "request inside 1 ms hold-off", longint'(vec), 3);
    repeat (1100) @(negedge clk);
    req_one(1'b1, 6'b000111, "R4");
    req_one(1'b1, 6'b001111, "R4");
    @(negedge clk);
    chk(pwm_duty == 8'hDF, "R8", "duty at PWM stage", longint'(pwm_duty), 8'hDF);
    req_one(1'b1, 6'b111111, "R5");
    drain("R6");
    req_one(1'b0, 6'b0, "R9");
    wait_mode = 1'b1;
    req_one(1'b0, 6'b0, "R9");
    repeat (10) @(negedge clk);
    chk(vec == 6'b111111, "R9", "requests after done", longint'(vec), 6'h3F);

    // tick gating and exact millisecond boundary
    do_reset();
    wait_mode = 1'b0; us_tick = 1'b0;
    g0 = 16'd1;
    req_one(1'b0, 6'b0, "R3");
    repeat (3000) @(negedge clk);
    req_one(1'b0, 6'b0, "R11");
    repeat (3) @(negedge clk);
    chk(vec == 6'b0, "R11", "no progress without ticks", longint'(vec), 0);
    @(negedge clk); us_tick = 1'b1;
    repeat (TPM - 1) @(negedge clk);
    us_tick = 1'b0;
    req_one(1'b0, 6'b0, "R4");
    repeat (3) @(negedge clk);
    chk(vec == 6'b0, "R4", "one tick short of 1 ms", longint'(vec), 0);
    us_tick = 1'b1;
    @(negedge clk);
    us_tick = 1'b0;
    req_one(1'b1, 6'b000001, "R4");
    drain("R4");

    // reset clears everything
    do_reset();
    repeat (5) @(negedge clk);
    chk(vec == 6'b0, "R10", "enables stay low until stepped", longint'(vec), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule